// File: doc/BRIEF.md
# Parity-Checked Asynchronous Control Register Port

This block is the register slave that a station-management controller reaches over a strobe-and-acknowledge bus with no shared clock. The host places a 6-bit address, a read/write select, a byte and its parity bit on the bus, then pulls the active-low select low. The block brings the strobe into its own clock domain, performs the access, and pulls an active-low acknowledge low. The acknowledge stays low until the host releases the strobe. Read data comes back on a separate output byte with its own parity bit, and both stay constant while the acknowledge is low.

Every byte crossing the port carries odd parity. When a write arrives with bad parity, the target register is left alone and a parity-error flag is set in an interrupt-condition register. That register is gated by a mask register to drive an active-low interrupt output. The implemented registers are a mode register, a user register whose two low bits drive two enable outputs, the interrupt-condition and mask pair, and a small bank of scratch registers. Every other address in the 64-entry space reads as zero.

Top module: `cbus_regport`

## Requirements
- R1: While `rst` is high and after it is released: `ack_n`=1, `irq_n`=1, `user_en`=0, and every address reads 0x00 (mode register bit 0 = 0, stop mode).
- R2: With default parameters, if `sel_n` is driven low before a rising edge, `ack_n` falls at the 4th rising edge counted from that edge (two synchronizer stages plus a fixed two-cycle delay).
- R3: `ack_n` stays low for as long as `sel_n` stays low, and it rises at the 3rd rising edge after `sel_n` returns high. A strobe held low performs exactly one access.
- R4: A read (`rd_wr`=1) returns the register contents on `rdata`, with `rpar` set so that the 9 bits {`rdata`,`rpar`} contain an odd number of ones. Both outputs stay unchanged while `ack_n` is low.
- R5: A write (`rd_wr`=0) with correct odd parity stores `wdata` into the mode register (address 0x00), the user register (0x01), the mask register (0x09) and the scratch registers (0x20 to 0x27).
- R6: A write whose 9 bits {`wdata`,`wpar`} hold an even number of ones leaves every register unchanged, including the condition register's clear action, and sets condition bit 0 (address 0x08).
- R7: The condition register at 0x08 clears a bit when a correct-parity write has a 1 in that position. Writing 0 leaves the bit alone, and bits 7:1 always read 0.
- R8: `irq_n` is low exactly when some bit is 1 in both the condition register and the mask register (0x09, where 1 enables), and it follows a change one cycle after the register update.
- R9: `user_en[0]` follows bit 0 and `user_en[1]` follows bit 1 of the user register at 0x01 (1 = asserted).
- R10: Addresses with no register read 0x00 with `rpar`=1, and writes to them have no visible effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Asynchronous active-low cycle strobe |
| rd_wr | input | 1 | 1 = read, 0 = write |
| addr | input | 6 | Register address, bit 5 most significant |
| wdata | input | 8 | Write data from host |
| wpar | input | 1 | Odd parity bit for wdata |
| rdata | output | 8 | Read data to host |
| rpar | output | 1 | Odd parity bit for rdata |
| ack_n | output | 1 | Active-low cycle acknowledge |
| irq_n | output | 1 | Active-low interrupt |
| user_en | output | 2 | General-purpose enables from the user register |

## Verification
The situation hardest to reach from the ports is a bad-parity write that collides with the condition register's own write-one-to-clear path, because a blocked write must neither clear the flag nor change its target. The bench first raises the flag and enables it in the mask. It then sends a wrong-parity write of 0x01 straight at the condition register and checks that the flag and the interrupt both survive. After that, a correct-parity 0xFE write must leave the flag set, and only a correct-parity 0x01 write may clear it. The bench also sweeps all 256 data values through the scratch bank and reads the whole address map back against its own model, which checks parity on every response.

// File: rtl/cbus_pkg.sv
package cbus_pkg;

    localparam int ADDR_W = 6;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] A_MODE = 6'h00;
    localparam logic [ADDR_W-1:0] A_USER = 6'h01;
    localparam logic [ADDR_W-1:0] A_COND = 6'h08;
    localparam logic [ADDR_W-1:0] A_MASK = 6'h09;
    localparam logic [ADDR_W-1:0] A_SCR  = 6'h20;

    localparam logic [DATA_W-1:0] COND_IMPL = 8'h01;
    localparam int COND_PERR_BIT = 0;

    typedef enum logic [1:0] {
        HS_IDLE = 2'd0,
        HS_WAIT = 2'd1,
        HS_ACK  = 2'd2
    } hs_state_e;

    typedef struct packed {
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              par;
    } cbus_req_t;

    typedef struct packed {
        logic              wr_ok;
        logic              wr_bad;
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } cbus_op_t;

    function automatic logic odd_par(input logic [DATA_W-1:0] d);
        return ~(^d);
    endfunction

    function automatic logic par_good(input logic [DATA_W-1:0] d, input logic p);
        return ^{d, p};
    endfunction

endpackage

// File: rtl/cbus_handshake.sv
module cbus_handshake
    import cbus_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ACK_DELAY   = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sel_n,
    output logic sel_s,
    output logic commit,
    output logic ack_n
);
    localparam int CNT_W = (ACK_DELAY > 2) ? $clog2(ACK_DELAY) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ACK_DELAY - 2);

    logic [SYNC_STAGES-1:0] sync_q;
    hs_state_e              state_q;
    logic [CNT_W-1:0]       cnt_q;
    logic                   ack_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], sel_n};
        end
    end

    assign sel_s  = sync_q[SYNC_STAGES-1];
    assign commit = (state_q == HS_WAIT) && (cnt_q == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= HS_IDLE;
            cnt_q   <= '0;
            ack_q   <= 1'b0;
        end else begin
            case (state_q)
                HS_IDLE: begin
                    if (!sel_s) begin
                        state_q <= HS_WAIT;
                        cnt_q   <= '0;
                    end
                end
                HS_WAIT: begin
                    if (commit) begin
                        state_q <= HS_ACK;
                        ack_q   <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                HS_ACK: begin
                    if (sel_s) begin
                        state_q <= HS_IDLE;
                        ack_q   <= 1'b0;
                    end
                end
                default: begin
                    state_q <= HS_IDLE;
                    ack_q   <= 1'b0;
                end
            endcase
        end
    end

    assign ack_n = ~ack_q;

endmodule

// File: rtl/cbus_irq_ctrl.sv
module cbus_irq_ctrl
    import cbus_pkg::*;
#(
    parameter logic [DATA_W-1:0] IMPL = COND_IMPL
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              perr_evt,
    input  logic              cond_we,
    input  logic              mask_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] cond,
    output logic [DATA_W-1:0] mask,
    output logic              irq_n
);
    logic [DATA_W-1:0] cond_q;
    logic [DATA_W-1:0] mask_q;
    logic [DATA_W-1:0] set_vec;
    logic [DATA_W-1:0] clr_vec;
    logic              irq_q;

    always_comb begin
        set_vec = '0;
        set_vec[COND_PERR_BIT] = perr_evt;
        clr_vec = cond_we ? wdata : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cond_q <= '0;
            mask_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            cond_q <= ((cond_q & ~clr_vec) | set_vec) & IMPL;
            if (mask_we) begin
                mask_q <= wdata;
            end
            irq_q <= |(cond_q & mask_q);
        end
    end

    assign cond  = cond_q;
    assign mask  = mask_q;
    assign irq_n = ~irq_q;

endmodule

// File: rtl/cbus_regbank.sv
module cbus_regbank
    import cbus_pkg::*;
#(
    parameter int NUM_SCRATCH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  cbus_req_t         req,
    input  logic [DATA_W-1:0] cond,
    input  logic [DATA_W-1:0] mask,
    output cbus_op_t          op,
    output logic [DATA_W-1:0] user_reg,
    output logic [DATA_W-1:0] rdata,
    output logic              rpar
);
    localparam int SCR_LAST = int'(A_SCR) + NUM_SCRATCH - 1;

    logic [DATA_W-1:0] mode_q;
    logic [DATA_W-1:0] user_q;
    logic [DATA_W-1:0] scr_q [NUM_SCRATCH];
    logic [DATA_W-1:0] rd_val;
    logic [DATA_W-1:0] rdata_q;
    logic              rpar_q;

    always_comb begin
        op.rd     = commit && req.rd;
        op.wr_ok  = commit && !req.rd && par_good(req.data, req.par);
        op.wr_bad = commit && !req.rd && !par_good(req.data, req.par);
        op.addr   = req.addr;
        op.data   = req.data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            user_q <= '0;
        end else if (op.wr_ok) begin
            if (op.addr == A_MODE) mode_q <= op.data;
            if (op.addr == A_USER) user_q <= op.data;
        end
    end

    for (genvar g = 0; g < NUM_SCRATCH; g++) begin : g_scr
        localparam logic [ADDR_W-1:0] SCR_ADDR = A_SCR + ADDR_W'(g);
        always_ff @(posedge clk) begin
            if (rst) begin
                scr_q[g] <= '0;
            end else if (op.wr_ok && op.addr == SCR_ADDR) begin
                scr_q[g] <= op.data;
            end
        end
    end

    always_comb begin
        rd_val = '0;
        case (req.addr)
            A_MODE:  rd_val = mode_q;
            A_USER:  rd_val = user_q;
            A_COND:  rd_val = cond;
            A_MASK:  rd_val = mask;
            default: begin
                for (int i = 0; i < NUM_SCRATCH; i++) begin
                    if (int'(req.addr) == int'(A_SCR) + i) rd_val = scr_q[i];
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
            rpar_q  <= 1'b1;
        end else if (op.rd) begin
            rdata_q <= rd_val;
            rpar_q  <= odd_par(rd_val);
        end
    end

    assign user_reg = user_q;
    assign rdata    = rdata_q;
    assign rpar     = rpar_q;

    initial begin
        if (SCR_LAST >= (1 << ADDR_W)) $error("scratch bank exceeds address space");
    end

endmodule

// File: rtl/cbus_regport.sv
module cbus_regport
    import cbus_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ACK_DELAY   = 2,
    parameter int NUM_SCRATCH = 8,
    parameter int NUM_EN      = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              rd_wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wpar,
    output logic [DATA_W-1:0] rdata,
    output logic              rpar,
    output logic              ack_n,
    output logic              irq_n,
    output logic [NUM_EN-1:0] user_en
);
    logic              sel_s;
    logic              commit;
    cbus_req_t         req;
    cbus_op_t          op;
    logic [DATA_W-1:0] cond;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] user_reg;
    logic              perr_evt;

    assign req.rd   = rd_wr;
    assign req.addr = addr;
    assign req.data = wdata;
    assign req.par  = wpar;

    cbus_handshake #(
        .SYNC_STAGES (SYNC_STAGES),
        .ACK_DELAY   (ACK_DELAY)
    ) u_hs (
        .clk    (clk),
        .rst    (rst),
        .sel_n  (sel_n),
        .sel_s  (sel_s),
        .commit (commit),
        .ack_n  (ack_n)
    );

    cbus_regbank #(
        .NUM_SCRATCH (NUM_SCRATCH)
    ) u_bank (
        .clk      (clk),
        .rst      (rst),
        .commit   (commit),
        .req      (req),
        .cond     (cond),
        .mask     (mask),
        .op       (op),
        .user_reg (user_reg),
        .rdata    (rdata),
        .rpar     (rpar)
    );

    assign perr_evt = op.wr_bad;

    cbus_irq_ctrl #(
        .IMPL (COND_IMPL)
    ) u_irq (
        .clk      (clk),
        .rst      (rst),
        .perr_evt (perr_evt),
        .cond_we  (op.wr_ok && op.addr == A_COND),
        .mask_we  (op.wr_ok && op.addr == A_MASK),
        .wdata    (op.data),
        .cond     (cond),
        .mask     (mask),
        .irq_n    (irq_n)
    );

    for (genvar g = 0; g < NUM_EN; g++) begin : g_en
        assign user_en[g] = user_reg[g];
    end

endmodule

// File: rtl/cbus_regport_chk.sv
module cbus_regport_chk
    import cbus_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              sel_s,
    input logic              ack_n,
    input logic              irq_n,
    input logic [DATA_W-1:0] rdata,
    input logic              rpar,
    input logic              perr_evt,
    input logic [DATA_W-1:0] cond,
    input logic [DATA_W-1:0] mask
);
    AST_ACK_WAITS_SYNC: assert property (@(posedge clk) disable iff (rst) $fell(ack_n) |-> !sel_s); // R2
    AST_ACK_HELD: assert property (@(posedge clk) disable iff (rst) (!ack_n && !sel_s) |=> !ack_n); // R3
    AST_RD_ODD_PARITY: assert property (@(posedge clk) disable iff (rst) !ack_n |-> ^{rdata, rpar}); // R4
    AST_RD_HELD: assert property (@(posedge clk) disable iff (rst) (!ack_n && !$past(ack_n)) |-> ($stable(rdata) && $stable(rpar))); // R4
    AST_PERR_RAISES_FLAG: assert property (@(posedge clk) disable iff (rst) perr_evt |=> cond[COND_PERR_BIT]); // R6
    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst) (mask == '0) |=> irq_n); // R8
endmodule

bind cbus_regport cbus_regport_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .sel_s    (sel_s),
    .ack_n    (ack_n),
    .irq_n    (irq_n),
    .rdata    (rdata),
    .rpar     (rpar),
    .perr_evt (perr_evt),
    .cond     (cond),
    .mask     (mask)
);

// File: tb/cbus_regport_tb.sv
module cbus_regport_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel_n = 1'b1;
    logic       rd_wr = 1'b1;
    logic [5:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       wpar = 1'b1;
    logic [7:0] rdata;
    logic       rpar;
    logic       ack_n;
    logic       irq_n;
    logic [1:0] user_en;

    int nchk = 0;
    int nerr = 0;
    int cyc = 0;
    int hold_err = 0;
    logic [7:0] model [64];

    always #10 clk = ~clk;

    cbus_regport u_dut (
        .clk(clk), .rst(rst), .sel_n(sel_n), .rd_wr(rd_wr), .addr(addr),
        .wdata(wdata), .wpar(wpar), .rdata(rdata), .rpar(rpar),
        .ack_n(ack_n), .irq_n(irq_n), .user_en(user_en)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            nerr++;
            $display("FAIL watchdog act=%0d exp=<150000", cyc);
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic good_par(input logic [7:0] d);
        int ones = 0;
        for (int i = 0; i < 8; i++) ones += int'(d[i]);
        return (ones % 2) == 0;
    endfunction

    function automatic bit storable(input logic [5:0] a);
        return a == 6'h00 || a == 6'h01 || a == 6'h09 || (a >= 6'h20 && a <= 6'h27);
    endfunction

    task automatic access(input logic rd, input logic [5:0] a, input logic [7:0] d,
                          input logic p, input int hold,
                          output logic [7:0] q, output logic qp, output int lat, output int rel);
        @(negedge clk);
        rd_wr = rd; addr = a; wdata = d; wpar = p; sel_n = 1'b0;
        lat = 0;
        do begin
            @(posedge clk); lat++; @(negedge clk);
        end while (ack_n && lat < 20);
        q = rdata; qp = rpar;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            if (ack_n || rdata != q || rpar != qp) hold_err++;
        end
        sel_n = 1'b1;
        rel = 0;
        do begin
            @(posedge clk); rel++; @(negedge clk);
        end while (!ack_n && rel < 20);
        repeat (2) @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        logic [7:0] q; logic qp; int l; int r;
        access(1'b0, a, d, good_par(d), 0, q, qp, l, r);
        if (storable(a)) model[a] = d;
        else if (a == 6'h08) model[a] = model[a] & ~d;
    endtask

    task automatic wr_bad(input logic [5:0] a, input logic [7:0] d);
        logic [7:0] q; logic qp; int l; int r;
        access(1'b0, a, d, ~good_par(d), 0, q, qp, l, r);
        model[8] = 8'h01;
    endtask

    task automatic rd_chk(input string tag, input logic [5:0] a);
        logic [7:0] q; logic qp; int l; int r;
        access(1'b1, a, 8'h00, 1'b1, 0, q, qp, l, r);
        check(tag, int'(q), int'(model[a]));
        check({tag, " parity"}, int'(qp), int'(good_par(model[a])));
    endtask

    initial begin
        logic [7:0] q; logic qp; int l; int r;
        for (int i = 0; i < 64; i++) model[i] = 8'h00;
        repeat (5) @(negedge clk);
        check("R1 ack_n during reset", int'(ack_n), 1);
        rst = 1'b0;
        @(negedge clk);
        check("R1 ack_n", int'(ack_n), 1);
        check("R1 irq_n", int'(irq_n), 1);
        check("R1 user_en", int'(user_en), 0);

        // R2 / R3: latency of acknowledge assert and release
        access(1'b1, 6'h00, 8'h00, 1'b1, 0, q, qp, l, r);
        check("R2 ack latency", l, 4);
        check("R3 ack release", r, 3);
        check("R1 mode stop bit", int'(q), 0);

        // R1 / R10: whole map reads zero after reset
        for (int a = 0; a < 64; a++) rd_chk(storable(6'(a)) ? "R1 reset map" : "R10 empty addr", 6'(a));

        // R5 / R4: all byte values through the scratch bank
        for (int v = 0; v < 256; v++) begin
            logic [5:0] a = 6'h20 + 6'(v % 8);
            wr(a, 8'(v));
            rd_chk("R5 scratch sweep", a);
        end

        // R5 / R10: write every address, read whole map back
        for (int a = 0; a < 64; a++) if (a != 8) wr(6'(a), 8'(a) ^ 8'hA5);
        for (int a = 0; a < 64; a++) rd_chk(storable(6'(a)) ? "R5 map" : "R10 map", 6'(a));

        // R9: user enables
        for (int v = 0; v < 4; v++) begin
            wr(6'h01, 8'hC0 | 8'(v));
            check("R9 user_en", int'(user_en), v);
        end

        // R3 / R4: long strobe holds acknowledge and data
        hold_err = 0;
        access(1'b1, 6'h21, 8'h00, 1'b1, 12, q, qp, l, r);
        check("R3 R4 hold", hold_err, 0);
        check("R4 held data", int'(q), int'(model[6'h21]));

        // R6 / R7 / R8: parity error path
        wr(6'h09, 8'h00);
        wr(6'h00, 8'h3C);
        wr_bad(6'h00, 8'hFF);
        rd_chk("R6 mode unchanged", 6'h00);
        rd_chk("R6 flag set", 6'h08);
        check("R8 masked irq", int'(irq_n), 1);
        wr(6'h09, 8'hFE);
        check("R8 other mask bits", int'(irq_n), 1);
        wr(6'h09, 8'h01);
        check("R8 irq asserted", int'(irq_n), 0);
        wr_bad(6'h08, 8'h01);
        rd_chk("R6 blocked clear", 6'h08);
        check("R8 irq kept", int'(irq_n), 0);
        wr_bad(6'h09, 8'h00);
        rd_chk("R6 mask unchanged", 6'h09);
        wr(6'h08, 8'hFE);
        rd_chk("R7 zero write keeps", 6'h08);
        wr(6'h08, 8'h01);
        rd_chk("R7 cleared", 6'h08);
        check("R8 irq released", int'(irq_n), 1);

        // R1: reset from a busy state
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 64; i++) model[i] = 8'h00;
        @(negedge clk);
        check("R1 user_en after reset", int'(user_en), 0);
        check("R1 irq_n after reset", int'(irq_n), 1);
        rd_chk("R1 mode after reset", 6'h00);
        rd_chk("R1 mask after reset", 6'h09);

        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

endmodule